// File: doc/BRIEF.md
# Lane drive level adjust calculator

This block converts the per-lane drive change requests that a serial display link receiver reports during training into a single transmitter drive setting. It takes the worst-case (largest) voltage swing request and the largest pre-emphasis request across the active lanes. It then limits both values against the limits of the upstream transmitter. Swing and pre-emphasis are coupled, so the swing allowed gets smaller as pre-emphasis gets larger. The resulting setting is copied to one train-set byte per lane.

The training controller presents the two request status bytes, the active lane count and the two transmitter limits, then pulses `load`. On the next clock edge the four train-set bytes update. They hold until the next pulse. If a limit value is outside the legal pair {2, 3} at a load, a sticky error flag is raised. The flag clears only on reset.

Top module: `drive_adjust_calc`

## Requirements
- R1: After synchronous reset all train-set bytes read 0x00 and `cfg_err` reads 0.
- R2: Only lanes whose index is below `lane_cnt` (legal values 1, 2 and 4) contribute to the maximum swing and the maximum pre-emphasis. Requests from the other lanes have no effect.
- R3: Request layout: lane 0 is `adj_req[3:0]`, lane 1 is `adj_req[7:4]`, lane 2 is `adj_req[11:8]` and lane 3 is `adj_req[15:12]`. Within a lane nibble, bits [1:0] are swing and bits [3:2] are pre-emphasis.
- R4: If the maximum pre-emphasis request is greater than or equal to `preemph_lim`, pre-emphasis becomes `preemph_lim` and the pre-emphasis saturation flag is set. Otherwise the flag is clear.
- R5: After R4, swing is reduced to at most 3 minus the pre-emphasis level. This gives ceilings of 3, 2, 1 and 0 for pre-emphasis levels 0, 1, 2 and 3.
- R6: After R5, if swing is greater than or equal to `swing_lim`, swing becomes `swing_lim` and the swing saturation flag is set. Otherwise the flag is clear.
- R7: Train-set byte layout: swing in [1:0], swing saturation flag in [2], pre-emphasis in [4:3], pre-emphasis saturation flag in [5], and [7:6] always 0.
- R8: All four train-set bytes carry the same value, whatever the lane count.
- R9: Outputs update on the clock edge at which `load` is high. With `load` low they hold, even when the inputs change.
- R10: A load with `swing_lim` or `preemph_lim` below 2 sets `cfg_err`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for a new drive setting |
| adj_req | input | 16 | Adjust request bytes, lanes 0-1 in the low byte, lanes 2-3 in the high byte |
| lane_cnt | input | 3 | Number of active lanes |
| swing_lim | input | 2 | Transmitter maximum swing level |
| preemph_lim | input | 2 | Transmitter maximum pre-emphasis level |
| train_set | output | 32 | Four train-set bytes, lane 0 in bits [7:0] |
| cfg_err | output | 1 | Sticky illegal-limit flag |

## Verification
On every cycle the bound checker verifies the following:
- the four bytes are identical;
- the reserved bits are zero;
- swing plus pre-emphasis never exceeds 3;
- a set saturation flag carries exactly the limit that was loaded;
- outputs hold without a load;
- the error flag is raised by an illegal limit and stays set.

Only the bench's scenarios can show that the right lanes are selected for each lane count, that the nibble positions are decoded correctly, and that each clamp step takes effect at the correct threshold. The bench does this by comparing against an independent model.

// File: rtl/drive_adj_pkg.sv
package drive_adj_pkg;
  localparam int LVL_W  = 2;
  localparam int NIB_W  = 2 * LVL_W;
  localparam int BYTE_W = 8;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       pre_sat;
    lvl_t       pre;
    logic       sw_sat;
    lvl_t       sw;
  } tset_t;

  // Highest swing permitted at a given pre-emphasis level
  function automatic lvl_t swing_ceiling(lvl_t pre);
    return lvl_t'(3) - pre;
  endfunction
endpackage

// File: rtl/lane_req_reduce.sv
module lane_req_reduce
  import drive_adj_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 3
) (
  input  logic [NUM_LANES*NIB_W-1:0] req,
  input  logic [CNT_W-1:0]           lane_cnt,
  output lvl_t                       sw_max,
  output lvl_t                       pre_max
);
  lvl_t lane_sw  [NUM_LANES];
  lvl_t lane_pre [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_sw[g]  = req[g*NIB_W +: LVL_W];
    assign lane_pre[g] = req[g*NIB_W + LVL_W +: LVL_W];
  end

  always_comb begin
    sw_max  = '0;
    pre_max = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (CNT_W'(i) < lane_cnt) begin
        if (lane_sw[i] > sw_max)   sw_max  = lane_sw[i];
        if (lane_pre[i] > pre_max) pre_max = lane_pre[i];
      end
    end
  end
endmodule

// File: rtl/drive_level_clamp.sv
module drive_level_clamp
  import drive_adj_pkg::*;
(
  input  lvl_t  sw_req,
  input  lvl_t  pre_req,
  input  lvl_t  sw_lim,
  input  lvl_t  pre_lim,
  output tset_t setting
);
  lvl_t pre_c;
  logic pre_sat;
  lvl_t ceil_v;
  lvl_t sw_c;
  lvl_t sw_f;
  logic sw_sat;

  always_comb begin
    // pre-emphasis saturates first
    pre_sat = (pre_req >= pre_lim);
    pre_c   = pre_sat ? pre_lim : pre_req;
    // swing bounded by the coupling ceiling
    ceil_v  = swing_ceiling(pre_c);
    sw_c    = (sw_req > ceil_v) ? ceil_v : sw_req;
    // then swing saturates against its own limit
    sw_sat  = (sw_c >= sw_lim);
    sw_f    = sw_sat ? sw_lim : sw_c;

    setting         = '0;
    setting.pre_sat = pre_sat;
    setting.pre     = pre_c;
    setting.sw_sat  = sw_sat;
    setting.sw      = sw_f;
  end
endmodule

// File: rtl/drive_adjust_calc.sv
module drive_adjust_calc
  import drive_adj_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int REQ_W    = NUM_LANES * NIB_W,
  localparam int CNT_W    = $clog2(NUM_LANES + 1),
  localparam int OUT_W    = NUM_LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REQ_W-1:0] adj_req,
  input  logic [CNT_W-1:0] lane_cnt,
  input  logic [1:0]       swing_lim,
  input  logic [1:0]       preemph_lim,
  output logic [OUT_W-1:0] train_set,
  output logic             cfg_err
);
  localparam lvl_t LIM_MIN = lvl_t'(2);

  lvl_t  sw_max;
  lvl_t  pre_max;
  tset_t next_set;
  tset_t set_q;
  logic  err_q;
  logic  lim_bad;

  lane_req_reduce #(
    .NUM_LANES (NUM_LANES),
    .CNT_W     (CNT_W)
  ) u_reduce (
    .req      (adj_req),
    .lane_cnt (lane_cnt),
    .sw_max   (sw_max),
    .pre_max  (pre_max)
  );

  drive_level_clamp u_clamp (
    .sw_req  (sw_max),
    .pre_req (pre_max),
    .sw_lim  (swing_lim),
    .pre_lim (preemph_lim),
    .setting (next_set)
  );

  assign lim_bad = (swing_lim < LIM_MIN) || (preemph_lim < LIM_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      set_q <= next_set;
      if (lim_bad) err_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_fan
    assign train_set[g*BYTE_W +: BYTE_W] = set_q;
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/drive_adjust_calc_chk.sv
module drive_adjust_calc_chk #(
  parameter int NUM_LANES = 4,
  localparam int OUT_W    = NUM_LANES * 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [1:0]       swing_lim,
  input logic [1:0]       preemph_lim,
  input logic [OUT_W-1:0] train_set,
  input logic             cfg_err
);
  logic [7:0] b0;
  logic       all_same;
  assign b0 = train_set[7:0];

  always_comb begin
    all_same = 1'b1;
    for (int i = 1; i < NUM_LANES; i++)
      if (train_set[i*8 +: 8] != b0) all_same = 1'b0;
  end

  p_lanes_equal_r8: assert property (@(posedge clk) disable iff (rst)
    all_same);

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    b0[7:6] == 2'b00);

  p_coupling_r5: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, b0[1:0]} + {1'b0, b0[4:3]}) <= 3'd3);

  p_pre_sat_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (!b0[5] || (b0[4:3] == $past(preemph_lim))));

  p_sw_sat_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> (!b0[2] || (b0[1:0] == $past(swing_lim))));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(train_set));

  p_err_set_r10: assert property (@(posedge clk) disable iff (rst)
    (load && ((swing_lim < 2'd2) || (preemph_lim < 2'd2))) |=> cfg_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind drive_adjust_calc drive_adjust_calc_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load        (load),
  .swing_lim   (swing_lim),
  .preemph_lim (preemph_lim),
  .train_set   (train_set),
  .cfg_err     (cfg_err)
);

// File: tb/tb_drive_adjust_calc.sv
module tb_drive_adjust_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [15:0] adj_req = '0;
  logic [2:0]  lane_cnt = 3'd4;
  logic [1:0]  swing_lim = 2'd3;
  logic [1:0]  preemph_lim = 2'd3;
  logic [31:0] train_set;
  logic        cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_err = 1'b0;
  logic [7:0] last_byte = 8'h00;

  typedef struct {
    logic [7:0] byte_v;
    logic       err;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  drive_adjust_calc dut (
    .clk(clk), .rst(rst), .load(load), .adj_req(adj_req), .lane_cnt(lane_cnt),
    .swing_lim(swing_lim), .preemph_lim(preemph_lim),
    .train_set(train_set), .cfg_err(cfg_err)
  );

  // Independent model built from the requirement text
  function automatic logic [7:0] model(logic [15:0] r, int cnt, int vl, int pl);
    int v = 0, p = 0, ceil_v;
    bit vf, pf;
    for (int i = 0; i < 4; i++) begin
      if (i < cnt) begin
        if (int'(r[i*4 +: 2]) > v)     v = int'(r[i*4 +: 2]);
        if (int'(r[i*4 + 2 +: 2]) > p) p = int'(r[i*4 + 2 +: 2]);
      end
    end
    pf = (p >= pl); if (pf) p = pl;
    ceil_v = 3 - p; if (v > ceil_v) v = ceil_v;
    vf = (v >= vl); if (vf) v = vl;
    return {2'b00, pf, p[1:0], vf, v[1:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [15:0] r, int cnt, int vl, int pl);
    exp_t e;
    @(negedge clk);
    adj_req = r; lane_cnt = 3'(cnt); swing_lim = 2'(vl); preemph_lim = 2'(pl);
    load = 1'b1;
    if (vl < 2 || pl < 2) model_err = 1'b1;
    e.byte_v = model(r, cnt, vl, pl);
    e.err = model_err;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; load = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_err = 1'b0;
    last_byte = 8'h00;
    check("R1 reset train_set", train_set, 32'h0);
    check("R1 reset cfg_err", {31'b0, cfg_err}, 32'h0);
  endtask

  // Monitor: samples 1 ns after each edge where a load was captured
  initial begin
    forever begin
      bit ld;
      @(posedge clk);
      ld = load && !rst;
      #1;
      if (ld && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        last_byte = e.byte_v;
        check(e.tag, train_set, {4{e.byte_v}});
        check({e.tag, " cfg_err"}, {31'b0, cfg_err}, {31'b0, e.err});
      end
    end
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R2/R3: one lane, other lanes ignored
    drive("R2 one lane", 16'hFFF1, 1, 3, 3);          // 0x01
    // R2/R3: two lanes, lane1 swing 2 from upper nibble
    drive("R3 two lanes", 16'hFF24, 2, 3, 3);         // 0x0A
    // R2: four lanes, lane3 pre 1 and lane2 swing 2
    drive("R2 four lanes", 16'h4200, 4, 3, 3);        // 0x0A
    // R4/R5: pre saturates at 2, swing ceiling 1
    drive("R4 pre sat", 16'h000F, 4, 3, 2);           // 0x31
    // R6: swing saturates at 2
    drive("R6 swing sat 2", 16'h0002, 4, 2, 3);       // 0x06
    drive("R6 swing sat 3", 16'h0003, 4, 3, 3);       // 0x07
    // R5: pre 3 forces swing 0
    drive("R5 pre3 ceiling", 16'h000F, 4, 2, 3);      // 0x38
    // R5: pre 1 ceiling 2 below swing limit 3
    drive("R5 pre1 ceiling", 16'h0007, 1, 3, 3);      // 0x0A
    // R8: lane count 1 still fills all bytes
    drive("R8 all bytes", 16'h0005, 1, 3, 3);         // 0x09
    // R9: hold while inputs change without load
    @(negedge clk);
    adj_req = 16'hFFFF; swing_lim = 2'd2; preemph_lim = 2'd2;
    repeat (4) @(negedge clk);
    check("R9 hold", train_set, {4{last_byte}});
    // R10: illegal limit sets sticky error
    drive("R10 bad limit", 16'h0002, 4, 1, 3);        // 0x05
    drive("R10 sticky", 16'h0001, 4, 3, 3);
    @(negedge clk);
    check("R10 error stays", {31'b0, cfg_err}, 32'h1);
    do_reset();
    // Sweep of legal patterns
    for (int k = 0; k < 300; k++) begin
      int cnt_sel;
      logic [15:0] r;
      cnt_sel = $urandom_range(0, 2);
      r = 16'($urandom);
      drive("R2 R5 sweep", r, (cnt_sel == 0) ? 1 : (cnt_sel == 1 ? 2 : 4),
            $urandom_range(2, 3), $urandom_range(2, 3));
    end
    repeat (3) @(negedge clk);
    check("R1 queue drained", q.size(), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule